// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block holds the speculative mapping from architectural to physical registers in an out-of-order core. Each cycle the rename stage reads two source mappings and the old mapping of its destination, and may install a new physical register for that destination. Free-list management, reorder buffer storage and execution are handled elsewhere.

When the front end predicts a branch, it asks for a checkpoint. The block copies the entire map into a free snapshot slot and tags the slot with the branch identifier. Several branches can be unresolved at once, and they can resolve in any order. A correct prediction frees the branch's slot. A misprediction loads the saved copy back into the live map in a single cycle. It also frees that slot and the slot of every branch younger than it. On the next cycle the block raises a flush pulse carrying the branch identifier, so the reorder buffer can kill the younger work.

Each slot is a two-state machine. In state SLOT_FREE, an allocation moves it to SLOT_HELD. In SLOT_HELD, a release (a correct resolve of its own branch, a misprediction of its own branch, or a misprediction of an older branch) returns it to SLOT_FREE. A small age matrix records which held slot was allocated first.

Top module: `rename_ckpt_table`

## Requirements
- R1: After reset, every architectural register r maps to physical register r, all slots are free, `ckpt_ready` is 1 and `flush_valid` is 0.
- R2: `ren_psrc1`, `ren_psrc2` and `ren_old_phys` show the live map for the presented indices in the same cycle. A rename with `ren_valid` changes the entry for `ren_dst` from the next cycle on.
- R3: An accepted checkpoint stores the whole live map. A rename in the same cycle is part of the stored copy when `ckpt_ren_older` is 1, and is left out when it is 0.
- R4: A misprediction of a held branch puts the map back to that branch's stored copy in one cycle. Any rename presented in that cycle is dropped.
- R5: A misprediction frees the slot of the mispredicted branch and the slot of every branch checkpointed after it. Branches checkpointed before it stay held.
- R6: A correct resolve of a held branch frees only that branch's slot and leaves the live map unchanged.
- R7: `ckpt_ready` is 0 exactly when all slots are held. A checkpoint request made while `ckpt_ready` is 0 is ignored.
- R8: The cycle after a misprediction of a held branch, `flush_valid` is 1 and `flush_br_id` equals that branch identifier. In every other cycle `flush_valid` is 0.
- R9: A resolve whose identifier matches no held slot has no effect on the map, the slots or the flush output.
- R10: A checkpoint requested in the same cycle as a misprediction of a held branch is dropped, because it belongs to the wrong path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Install a new destination mapping this cycle |
| ren_src1 | input | ARCH_W | First source architectural index |
| ren_src2 | input | ARCH_W | Second source architectural index |
| ren_dst | input | ARCH_W | Destination architectural index |
| ren_new_phys | input | PHYS_W | Physical register given to the destination |
| ren_psrc1 | output | PHYS_W | Live mapping of ren_src1 |
| ren_psrc2 | output | PHYS_W | Live mapping of ren_src2 |
| ren_old_phys | output | PHYS_W | Live mapping of ren_dst before this rename |
| ckpt_valid | input | 1 | Request a snapshot for a predicted branch |
| ckpt_br_id | input | BID_W | Identifier of the branch being checkpointed |
| ckpt_ren_older | input | 1 | The same-cycle rename precedes the branch |
| ckpt_ready | output | 1 | At least one snapshot slot is free |
| res_valid | input | 1 | A branch resolves this cycle |
| res_br_id | input | BID_W | Identifier of the resolving branch |
| res_mispredict | input | 1 | 1 = mispredicted, 0 = correctly predicted |
| flush_valid | output | 1 | Kill work younger than flush_br_id |
| flush_br_id | output | BID_W | Identifier of the mispredicted branch |

## Verification
Some properties are checked on every cycle. After a restore, the live map equals the selected stored copy. A non-dropped rename lands in its entry. The map does not change when it is neither written nor restored. A slot is allocated only from SLOT_FREE and released only from SLOT_HELD. At most one slot is allocated and at most one matches a resolve. The younger slots are actually free after a misprediction, and the flush pulse carries the right identifier. Other behaviour shows only in the bench scenarios, where a reference map and its saved copies are compared through the rename read ports. These cover whether a same-cycle rename enters the snapshot, whether older branches survive a nested misprediction, whether a resolve of a freed or unknown branch is ignored, and whether a wrong-path checkpoint is dropped.

// File: rtl/rct_pkg.sv
package rct_pkg;

    typedef enum logic [0:0] {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/rct_map.sv
module rct_map #(
    parameter int ARCH_N = 32,
    parameter int PHYS_W = 6,
    localparam int ARCH_W = $clog2(ARCH_N),
    localparam int IMG_W  = ARCH_N * PHYS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_arch,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic              restore_en,
    input  logic [IMG_W-1:0]  restore_img,
    output logic [IMG_W-1:0]  map_flat
);

    logic [PHYS_W-1:0] ent_q [ARCH_N];

    // Live map: restore has priority over a rename write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_N; i++) begin
                ent_q[i] <= PHYS_W'(i);
            end
        end else if (restore_en) begin
            for (int i = 0; i < ARCH_N; i++) begin
                ent_q[i] <= restore_img[i*PHYS_W +: PHYS_W];
            end
        end else if (wr_en) begin
            ent_q[wr_arch] <= wr_phys;
        end
    end

    for (genvar g = 0; g < ARCH_N; g++) begin : g_flat
        assign map_flat[g*PHYS_W +: PHYS_W] = ent_q[g];
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !restore_en) |=> $stable(map_flat)); // R6

endmodule

// File: rtl/rct_slot.sv
module rct_slot
    import rct_pkg::*;
#(
    parameter int BID_W = 4,
    parameter int IMG_W = 192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [BID_W-1:0] alloc_bid,
    input  logic [IMG_W-1:0] alloc_img,
    input  logic             release_i,
    output logic             held,
    output logic [BID_W-1:0] bid,
    output logic [IMG_W-1:0] img
);

    slot_state_e      state_q, state_d;
    logic [BID_W-1:0] bid_q;
    logic [IMG_W-1:0] img_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (alloc)     state_d = SLOT_HELD;
            SLOT_HELD: if (release_i) state_d = SLOT_FREE;
            default:                  state_d = SLOT_FREE;
        endcase
    end

    // Payload: the branch tag and the copy of the map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bid_q <= '0;
            img_q <= '0;
        end else if (alloc) begin
            bid_q <= alloc_bid;
            img_q <= alloc_img;
        end
    end

    // Outputs.
    always_comb begin
        held = (state_q == SLOT_HELD);
        bid  = bid_q;
        img  = img_q;
    end

    AST_ALLOC_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state_q == SLOT_FREE)); // R7
    AST_RELEASE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> (state_q == SLOT_HELD)); // R5

endmodule

// File: rtl/rct_order.sv
module rct_order #(
    parameter int SLOTS = 4,
    parameter int BID_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       held,
    input  logic [SLOTS*BID_W-1:0] bids,
    input  logic                   ckpt_valid,
    input  logic                   res_valid,
    input  logic [BID_W-1:0]       res_bid,
    input  logic                   res_mis,
    output logic                   ready,
    output logic [SLOTS-1:0]       alloc_vec,
    output logic [SLOTS-1:0]       release_vec,
    output logic [SLOTS-1:0]       hit_vec,
    output logic                   mis_hit
);

    // older_q[i][j] = 1: slot i was allocated before slot j.
    logic [SLOTS-1:0] older_q [SLOTS];
    logic [SLOTS-1:0] kill_vec;
    logic             found;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            hit_vec[i] = res_valid && held[i] && (bids[i*BID_W +: BID_W] == res_bid);
        end
        mis_hit = res_mis && (|hit_vec);
        ready   = ~(&held);
    end

    // Slots younger than the resolving one.
    always_comb begin
        kill_vec = '0;
        for (int j = 0; j < SLOTS; j++) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit_vec[i] && older_q[i][j] && held[j]) begin
                    kill_vec[j] = 1'b1;
                end
            end
        end
        release_vec = hit_vec | (res_mis ? kill_vec : '0);
    end

    // Lowest free slot takes a new checkpoint; none on a wrong-path cycle.
    always_comb begin
        alloc_vec = '0;
        found     = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!held[i] && !found) begin
                alloc_vec[i] = ckpt_valid && !mis_hit;
                found        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                older_q[i] <= '0;
            end
        end else begin
            for (int k = 0; k < SLOTS; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < SLOTS; j++) begin
                        older_q[k][j] <= 1'b0;
                        older_q[j][k] <= (j != k);
                    end
                end
            end
        end
    end

    AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R7
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R6
    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mis_hit |=> ((held & $past(kill_vec)) == '0)); // R5

endmodule

// File: rtl/rename_ckpt_table.sv
module rename_ckpt_table #(
    parameter int NUM_ARCH  = 32,
    parameter int NUM_PHYS  = 64,
    parameter int NUM_SLOTS = 4,
    parameter int BID_W     = 4,
    localparam int ARCH_W   = $clog2(NUM_ARCH),
    localparam int PHYS_W   = $clog2(NUM_PHYS),
    localparam int IMG_W    = NUM_ARCH * PHYS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src1,
    input  logic [ARCH_W-1:0] ren_src2,
    input  logic [ARCH_W-1:0] ren_dst,
    input  logic [PHYS_W-1:0] ren_new_phys,
    output logic [PHYS_W-1:0] ren_psrc1,
    output logic [PHYS_W-1:0] ren_psrc2,
    output logic [PHYS_W-1:0] ren_old_phys,
    input  logic              ckpt_valid,
    input  logic [BID_W-1:0]  ckpt_br_id,
    input  logic              ckpt_ren_older,
    output logic              ckpt_ready,
    input  logic              res_valid,
    input  logic [BID_W-1:0]  res_br_id,
    input  logic              res_mispredict,
    output logic              flush_valid,
    output logic [BID_W-1:0]  flush_br_id
);

    logic [IMG_W-1:0]           map_flat;
    logic [PHYS_W-1:0]          map_arr [NUM_ARCH];
    logic [IMG_W-1:0]           snap_img;
    logic [IMG_W-1:0]           restore_img;
    logic [NUM_SLOTS-1:0]       held;
    logic [NUM_SLOTS*BID_W-1:0] bids;
    logic [IMG_W-1:0]           imgs [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]       alloc_vec;
    logic [NUM_SLOTS-1:0]       release_vec;
    logic [NUM_SLOTS-1:0]       hit_vec;
    logic                       mis_hit;

    rct_map #(
        .ARCH_N (NUM_ARCH),
        .PHYS_W (PHYS_W)
    ) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ren_valid && !mis_hit),
        .wr_arch     (ren_dst),
        .wr_phys     (ren_new_phys),
        .restore_en  (mis_hit),
        .restore_img (restore_img),
        .map_flat    (map_flat)
    );

    for (genvar g = 0; g < NUM_ARCH; g++) begin : g_view
        assign map_arr[g] = map_flat[g*PHYS_W +: PHYS_W];
    end

    assign ren_psrc1    = map_arr[ren_src1];
    assign ren_psrc2    = map_arr[ren_src2];
    assign ren_old_phys = map_arr[ren_dst];

    // Copy to store: includes the same-cycle rename only when it is older.
    always_comb begin
        snap_img = map_flat;
        for (int a = 0; a < NUM_ARCH; a++) begin
            if (ren_valid && ckpt_ren_older && (ren_dst == ARCH_W'(a))) begin
                snap_img[a*PHYS_W +: PHYS_W] = ren_new_phys;
            end
        end
    end

    rct_order #(
        .SLOTS (NUM_SLOTS),
        .BID_W (BID_W)
    ) u_order (
        .clk         (clk),
        .rst_n       (rst_n),
        .held        (held),
        .bids        (bids),
        .ckpt_valid  (ckpt_valid),
        .res_valid   (res_valid),
        .res_bid     (res_br_id),
        .res_mis     (res_mispredict),
        .ready       (ckpt_ready),
        .alloc_vec   (alloc_vec),
        .release_vec (release_vec),
        .hit_vec     (hit_vec),
        .mis_hit     (mis_hit)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        rct_slot #(
            .BID_W (BID_W),
            .IMG_W (IMG_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[s]),
            .alloc_bid (ckpt_br_id),
            .alloc_img (snap_img),
            .release_i (release_vec[s]),
            .held      (held[s]),
            .bid       (bids[s*BID_W +: BID_W]),
            .img       (imgs[s])
        );
    end

    // One-hot select of the stored copy.
    always_comb begin
        restore_img = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (hit_vec[s]) begin
                restore_img = restore_img | imgs[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_valid <= 1'b0;
            flush_br_id <= '0;
        end else begin
            flush_valid <= mis_hit;
            if (mis_hit) begin
                flush_br_id <= res_br_id;
            end
        end
    end

    AST_RESTORE_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mis_hit |=> (map_flat == $past(restore_img))); // R4
    AST_RENAME_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !mis_hit) |=> (map_arr[$past(ren_dst)] == $past(ren_new_phys))); // R2
    AST_READY_AFTER_MIS: assert property (@(posedge clk) disable iff (!rst_n)
        mis_hit |=> ckpt_ready); // R5
    AST_FLUSH_ID: assert property (@(posedge clk) disable iff (!rst_n)
        mis_hit |=> (flush_valid && (flush_br_id == $past(res_br_id)))); // R8

endmodule

// File: tb/rename_ckpt_table_bench.sv
`timescale 1ns/1ps
module rename_ckpt_table_bench;

    localparam int NA = 32;
    localparam int AW = 5;
    localparam int PW = 6;
    localparam int BW = 4;
    localparam int NS = 4;
    localparam int IW = NA * PW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ren_valid;
    logic [AW-1:0] ren_src1, ren_src2, ren_dst;
    logic [PW-1:0] ren_new_phys, ren_psrc1, ren_psrc2, ren_old_phys;
    logic          ckpt_valid, ckpt_ren_older, ckpt_ready;
    logic [BW-1:0] ckpt_br_id, res_br_id, flush_br_id;
    logic          res_valid, res_mispredict, flush_valid;

    always #2 clk = ~clk;

    rename_ckpt_table u_rename_ckpt_table (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_src1(ren_src1), .ren_src2(ren_src2),
        .ren_dst(ren_dst), .ren_new_phys(ren_new_phys),
        .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2), .ren_old_phys(ren_old_phys),
        .ckpt_valid(ckpt_valid), .ckpt_br_id(ckpt_br_id),
        .ckpt_ren_older(ckpt_ren_older), .ckpt_ready(ckpt_ready),
        .res_valid(res_valid), .res_br_id(res_br_id), .res_mispredict(res_mispredict),
        .flush_valid(flush_valid), .flush_br_id(flush_br_id)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard item kinds: 0 psrc1, 1 psrc2, 2 old_phys, 3 ready, 4 flush_valid, 5 flush_br_id
    typedef struct {
        int    cyc;
        int    kind;
        int    exp;
        string tag;
    } item_t;
    item_t sbq[$];

    typedef struct {
        int          id;
        logic [IW-1:0] img;
    } ck_t;
    ck_t ckq[$];
    logic [IW-1:0] ref_img;

    int  nvec  = 0;
    int  nfail = 0;
    bit  done  = 1'b0;
    bit  last_mis;

    function automatic int refget(int a);
        return int'(ref_img[a*PW +: PW]);
    endfunction

    task automatic push(int when, int kind, int exp, string tag);
        item_t it;
        it.cyc = when; it.kind = kind; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compares every item due in the current cycle.
    always @(negedge clk) begin
        int i;
        int act;
        i = 0;
        while (i < sbq.size()) begin
            if (sbq[i].cyc == cyc) begin
                case (sbq[i].kind)
                    0: act = int'(ren_psrc1);
                    1: act = int'(ren_psrc2);
                    2: act = int'(ren_old_phys);
                    3: act = int'(ckpt_ready);
                    4: act = int'(flush_valid);
                    default: act = int'(flush_br_id);
                endcase
                nvec++;
                if (act !== sbq[i].exp) begin
                    nfail++;
                    $display("FAIL %s kind=%0d actual=%0d expected=%0d cycle=%0d",
                             sbq[i].tag, sbq[i].kind, act, sbq[i].exp, cyc);
                end
                sbq.delete(i);
            end else begin
                i++;
            end
        end
    end

    // Driver: applies one cycle of stimulus and advances the reference model.
    task automatic tick(bit rv, int rd, int rp, bit older, bit cv, int cid,
                        bit sv, int sid, bit mis, string tag);
        int k;
        bit rdy, mhit;
        logic [IW-1:0] snap, nxt;
        ren_valid = rv; ren_dst = AW'(rd); ren_new_phys = PW'(rp);
        ren_src1 = AW'(rd); ren_src2 = '0;
        ckpt_valid = cv; ckpt_br_id = BW'(cid); ckpt_ren_older = older;
        res_valid = sv; res_br_id = BW'(sid); res_mispredict = mis;
        rdy = (ckq.size() < NS);
        push(cyc, 3, int'(rdy), tag);
        if (rv) push(cyc, 2, refget(rd), tag);
        k = -1;
        foreach (ckq[j]) if (ckq[j].id == sid) k = j;
        mhit = sv && mis && (k >= 0);
        push(cyc + 1, 4, int'(mhit), tag);
        if (mhit) push(cyc + 1, 5, sid, tag);
        snap = ref_img;
        nxt  = ref_img;
        if (rv && older && !mhit) snap[rd*PW +: PW] = PW'(rp);
        if (rv && !mhit) nxt[rd*PW +: PW] = PW'(rp);
        if (mhit) begin
            nxt = ckq[k].img;
            while (ckq.size() > k) void'(ckq.pop_back());
        end else if (sv && (k >= 0) && !mis) begin
            ckq.delete(k);
        end
        if (cv && rdy && !mhit) begin
            ck_t c;
            c.id = cid; c.img = snap;
            ckq.push_back(c);
        end
        ref_img  = nxt;
        last_mis = mhit;
        @(posedge clk); #1;
    endtask

    task automatic idle(string tag);
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Reads the whole live map through the source ports.
    task automatic check_map(string tag);
        for (int a = 0; a < NA; a += 2) begin
            ren_valid = 0; ckpt_valid = 0; res_valid = 0;
            ren_src1 = AW'(a); ren_src2 = AW'(a + 1);
            push(cyc, 0, refget(a), tag);
            push(cyc, 1, refget(a + 1), tag);
            @(posedge clk); #1;
        end
    endtask

    function automatic int free_id();
        int c;
        bit dup;
        do begin
            c = int'($urandom % 16);
            dup = 0;
            foreach (ckq[j]) if (ckq[j].id == c) dup = 1;
        end while (dup);
        return c;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        ren_valid = 0; ren_src1 = 0; ren_src2 = 0; ren_dst = 0; ren_new_phys = 0;
        ckpt_valid = 0; ckpt_br_id = 0; ckpt_ren_older = 0;
        res_valid = 0; res_br_id = 0; res_mispredict = 0;
        for (int a = 0; a < NA; a++) ref_img[a*PW +: PW] = PW'(a);
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: identity map, ready, no flush
        idle("R1");
        check_map("R1");

        // R2: write then read back through old_phys
        tick(1, 3, 40, 0, 0, 0, 0, 0, 0, "R2");
        tick(1, 3, 41, 0, 0, 0, 0, 0, 0, "R2");
        check_map("R2");

        // R3: same-cycle rename included (older) / excluded (younger)
        tick(1, 5, 42, 1, 1, 1, 0, 0, 0, "R3");
        tick(1, 6, 43, 0, 1, 2, 0, 0, 0, "R3");
        tick(1, 5, 50, 0, 0, 0, 0, 0, 0, "R3");
        tick(1, 6, 51, 0, 0, 0, 0, 0, 0, "R3");
        tick(1, 7, 52, 0, 0, 0, 1, 2, 1, "R4");
        idle("R8");
        check_map("R4");
        tick(0, 0, 0, 0, 0, 0, 1, 1, 1, "R3");
        check_map("R3");

        // R7: fill all slots, extra request ignored
        tick(1, 8, 20, 0, 1, 3, 0, 0, 0, "R7");
        tick(1, 9, 21, 0, 1, 4, 0, 0, 0, "R7");
        tick(1, 10, 22, 0, 1, 5, 0, 0, 0, "R7");
        tick(1, 11, 23, 0, 1, 6, 0, 0, 0, "R7");
        tick(1, 12, 24, 0, 1, 7, 0, 0, 0, "R7");
        idle("R7");
        // R6: correct resolve frees one slot, map unchanged
        tick(0, 0, 0, 0, 0, 0, 1, 4, 0, "R6");
        idle("R6");
        check_map("R6");
        // R5: nested misprediction kills younger slot 6, keeps 3
        tick(1, 13, 25, 0, 0, 0, 1, 5, 1, "R5");
        tick(0, 0, 0, 0, 0, 0, 1, 6, 1, "R5");
        check_map("R5");
        tick(0, 0, 0, 0, 1, 10, 0, 0, 0, "R5");
        tick(0, 0, 0, 0, 1, 11, 0, 0, 0, "R5");
        tick(0, 0, 0, 0, 0, 0, 1, 3, 1, "R5");
        idle("R5");
        check_map("R5");

        // R9: unknown identifier
        tick(1, 14, 30, 0, 0, 0, 1, 12, 1, "R9");
        tick(0, 0, 0, 0, 0, 0, 1, 13, 0, "R9");
        check_map("R9");

        // R10: checkpoint and rename on a mispredict cycle are dropped
        tick(1, 15, 31, 0, 1, 9, 0, 0, 0, "R10");
        tick(1, 15, 60, 1, 1, 8, 1, 9, 1, "R10");
        check_map("R10");
        tick(0, 0, 0, 0, 0, 0, 1, 8, 1, "R10");
        idle("R10");

        // Random branch traffic; map compared after every restore
        for (int n = 0; n < 1500; n++) begin
            bit rv, cv, sv, mis, older;
            int sid;
            rv = $urandom % 2; older = $urandom % 2;
            cv = ($urandom % 3) == 0;
            sv = ($urandom % 4) == 0;
            mis = $urandom % 2;
            if (ckq.size() > 0 && ($urandom % 4) != 0)
                sid = ckq[$urandom % ckq.size()].id;
            else
                sid = int'($urandom % 16);
            tick(rv, int'($urandom % NA), int'($urandom % 64), older,
                 cv, free_id(), sv, sid, mis, "R4");
            if (last_mis) check_map("R4");
        end
        idle("R8");
        check_map("R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule